// File: doc/BRIEF.md
# Special-Purpose Register Bank with Write Side Effects

This block holds a processor's special-purpose register space. Software moves values into it through a write port and out of it through a combinational read port, both addressed by a 16-bit register number. Most of the space is plain storage. A few register numbers are not storage at all: writing them sends a command to a cache, redirects instruction fetch, signals the memory-management unit, requests suspend, or passes the value to the general-purpose register file or the tick timer. Each of these effects appears as a one-clock strobe on a dedicated output port in the clock cycle after the write.

The write port folds the register number into the implemented 4096-entry space, so the top four index bits are ignored on writes. The read port does not fold: any read beyond the implemented space returns zero. Several read locations return live values from outside the block: the current and previous program counter, the timer count and the addressed general-purpose register. Translation-table entries for the data and instruction sides are stored with undefined bits stripped, and the status register keeps one bit that can never be cleared.

The caches, the MMU, the timer, the fetch unit and the general-purpose register file all sit outside this block. It reaches them only through strobe and data ports.

Top module: `spr_file`

## Requirements
- R1: A write uses only the low 12 bits of the index, so 0x3007 stores into 0x007. Any read whose index has one of its top four bits set returns zero.
- R2: A non-zero write to 0x040 or to 0x042 drives dc_cmd_valid_o high for exactly one cycle after the write. With it, dc_cmd_addr_o carries the value and dc_cmd_op_o carries 2'b01 (prefetch) for 0x040 or 2'b10 (invalidate) for 0x042. A zero write sends nothing. Both registers always read zero.
- R3: A write to 0x041 sends a data-cache command with op 2'b11 (flush) only when the value is not all ones. 0x041 always reads 0xFFFFFFFF.
- R4: Writes to 0x043, 0x044 and 0x04A send no command, and these registers always read zero.
- R5: A non-zero write to 0x048 drives ic_cmd_valid_o for one cycle with op 2'b01. A non-zero write to 0x049 does the same with op 2'b10. In both cases ic_cmd_addr_o carries the value. A zero write sends nothing.
- R6: The status register sits at 0x011 and resets to 0x00008000. After a write, flag_o equals bit 0 of the written value. Bit 15 of the status register always reads one.
- R7: A status write that sets bit 6 when it was clear gives a one-cycle pulse on immu_on_o. A write that clears bit 6 when it was set gives a one-cycle pulse on immu_off_o. A write that leaves bit 6 unchanged gives neither pulse.
- R8: A write to 0x010 gives a one-cycle redirect_o pulse with redirect_pc_o equal to the value and fetch_next_o equal to the value plus 4. This pulse also tells the fetch unit to drop any pending delay-slot branch. A read of 0x010 returns pc_i, and a read of 0x012 returns ppc_i.
- R9: The data-side table occupies 0x100-0x1FF and the instruction-side table occupies 0x200-0x2FF. Within each table, offset bit 7 clear selects a match entry and bit 7 set selects a translate entry. Entries 0-15 of each kind are implemented. A stored value keeps bits 31:13 (the page number) and its flag bits: 7:0 for match entries, 9:0 for data translate entries and 7:0 for instruction translate entries. All other bits are zero. Entries that are not implemented read zero.
- R10: A write to 0x400-0x41F gives a one-cycle gpr_wr_en_o pulse with gpr_wr_idx_o equal to index bits 4:0 and gpr_wr_data_o equal to the value. gpr_rd_idx_o always follows read index bits 4:0, and a read in this window returns gpr_rd_data_i.
- R11: A read of 0x020 returns tick_count_i. A write to 0x020 gives a one-cycle tick_wr_o pulse with tick_wr_data_o equal to the value.
- R12: A write to 0x030 stores the value. If bit 4 of the value is set, the write also gives a one-cycle suspend_o pulse. The other bits of 0x030 cause no effect at all.
- R13: Entries 0x000-0x00F are plain read/write storage, and unmapped locations read zero. After reset every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 16 | Write register number |
| wr_data_i | input | 32 | Write value |
| rd_idx_i | input | 16 | Read register number |
| rd_data_o | output | 32 | Read value (combinational) |
| pc_i | input | 32 | Current program counter |
| ppc_i | input | 32 | Previously executed program counter |
| tick_count_i | input | 32 | Live timer count |
| gpr_rd_data_i | input | 32 | General-purpose register read data |
| gpr_rd_idx_o | output | 5 | General-purpose register read index |
| gpr_wr_en_o | output | 1 | General-purpose register write strobe |
| gpr_wr_idx_o | output | 5 | General-purpose register write index |
| gpr_wr_data_o | output | 32 | General-purpose register write data |
| dc_cmd_valid_o | output | 1 | Data-cache command strobe |
| dc_cmd_op_o | output | 2 | Data-cache command kind |
| dc_cmd_addr_o | output | 32 | Data-cache command address |
| ic_cmd_valid_o | output | 1 | Instruction-cache command strobe |
| ic_cmd_op_o | output | 2 | Instruction-cache command kind |
| ic_cmd_addr_o | output | 32 | Instruction-cache command address |
| flag_o | output | 1 | Condition flag |
| immu_on_o | output | 1 | Instruction MMU enabled event |
| immu_off_o | output | 1 | Instruction MMU disabled event |
| redirect_o | output | 1 | Fetch redirect strobe, cancels delay slot |
| redirect_pc_o | output | 32 | New program counter |
| fetch_next_o | output | 32 | Following fetch address |
| tick_wr_o | output | 1 | Timer count write strobe |
| tick_wr_data_o | output | 32 | Timer count write value |
| suspend_o | output | 1 | Suspend request strobe |

## Verification
Some properties are checked on every cycle. Out-of-range reads must return zero, and bit 15 must be set whenever the status register is read. Cache commands must never carry a zero address (for prefetch and invalidate) or an all-ones address (for flush). The two MMU events must never be high together, and at most one side-effect strobe may fire in any cycle. Every strobe must trace back to a write in the previous cycle.

Other behaviour can only be shown by the bench's scenarios. These include the exact masking of table entries, the values read back from the self-clearing registers, index folding on writes, and whether the status flag and MMU edges follow the previous status value. The reference model tracks all of these across directed and random write sequences.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [4:0] {
    RG_NONE, RG_SCRATCH, RG_NPC, RG_SR, RG_PPC, RG_TICK, RG_PM,
    RG_DC_PF, RG_DC_FL, RG_DC_INV, RG_DC_WB, RG_DC_LK,
    RG_IC_PF, RG_IC_INV, RG_IC_LK, RG_DTLB, RG_ITLB, RG_GPR
  } spr_region_e;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_PREFETCH = 2'b01,
    CMD_INVAL    = 2'b10,
    CMD_FLUSH    = 2'b11
  } cache_op_e;

  localparam int ADR_NPC    = 'h010;
  localparam int ADR_SR     = 'h011;
  localparam int ADR_PPC    = 'h012;
  localparam int ADR_TICK   = 'h020;
  localparam int ADR_PM     = 'h030;
  localparam int ADR_DC_PF  = 'h040;
  localparam int ADR_DC_FL  = 'h041;
  localparam int ADR_DC_INV = 'h042;
  localparam int ADR_DC_WB  = 'h043;
  localparam int ADR_DC_LK  = 'h044;
  localparam int ADR_IC_PF  = 'h048;
  localparam int ADR_IC_INV = 'h049;
  localparam int ADR_IC_LK  = 'h04A;
  localparam int DTLB_BLK   = 'h1;
  localparam int ITLB_BLK   = 'h2;
  localparam int GPR_BASE   = 'h400;

  localparam int SR_F_BIT    = 0;
  localparam int SR_IME_BIT  = 6;
  localparam int SR_FO_BIT   = 15;
  localparam int PM_SUSP_BIT = 4;

endpackage

// File: rtl/spr_rst_sync.sv
module spr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int SPACE_W   = 12,
  parameter int SCRATCH_N = 16,
  parameter int GPR_N     = 32
) (
  input  logic [SPACE_W-1:0] idx_i,
  output spr_region_e        region_o
);
  int loc;

  always_comb begin
    loc      = int'(idx_i);
    region_o = RG_NONE;
    if (loc < SCRATCH_N)                                  region_o = RG_SCRATCH;
    else if ((loc >> 8) == DTLB_BLK)                      region_o = RG_DTLB;
    else if ((loc >> 8) == ITLB_BLK)                      region_o = RG_ITLB;
    else if (loc >= GPR_BASE && loc < GPR_BASE + GPR_N)   region_o = RG_GPR;
    else begin
      case (loc)
        ADR_NPC:    region_o = RG_NPC;
        ADR_SR:     region_o = RG_SR;
        ADR_PPC:    region_o = RG_PPC;
        ADR_TICK:   region_o = RG_TICK;
        ADR_PM:     region_o = RG_PM;
        ADR_DC_PF:  region_o = RG_DC_PF;
        ADR_DC_FL:  region_o = RG_DC_FL;
        ADR_DC_INV: region_o = RG_DC_INV;
        ADR_DC_WB:  region_o = RG_DC_WB;
        ADR_DC_LK:  region_o = RG_DC_LK;
        ADR_IC_PF:  region_o = RG_IC_PF;
        ADR_IC_INV: region_o = RG_IC_INV;
        ADR_IC_LK:  region_o = RG_IC_LK;
        default:    region_o = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spr_tlb_bank.sv
module spr_tlb_bank #(
  parameter int              DATA_W    = 32,
  parameter int              SETS      = 16,
  parameter int              PAGE_BITS = 13,
  parameter logic [31:0]     MT_FLAGS  = 32'h0000_00FF,
  parameter logic [31:0]     XL_FLAGS  = 32'h0000_00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [7:0]        rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int                SET_W     = (SETS > 1) ? $clog2(SETS) : 1;
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_BITS) - DATA_W'(1));
  localparam logic [DATA_W-1:0] MT_KEEP   = PAGE_MASK | DATA_W'(MT_FLAGS);
  localparam logic [DATA_W-1:0] XL_KEEP   = PAGE_MASK | DATA_W'(XL_FLAGS);

  logic [SETS-1:0][DATA_W-1:0] mt_all;
  logic [SETS-1:0][DATA_W-1:0] xl_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic              hit, mt_we, xl_we;
    logic [DATA_W-1:0] mt_q, xl_q;

    assign hit   = wr_i && (int'(wr_off_i[6:0]) == s);
    assign mt_we = hit && !wr_off_i[7];
    assign xl_we = hit &&  wr_off_i[7];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mt_q <= '0;
        xl_q <= '0;
      end else begin
        if (mt_we) mt_q <= wr_data_i & MT_KEEP;
        if (xl_we) xl_q <= wr_data_i & XL_KEEP;
      end
    end

    assign mt_all[s] = mt_q;
    assign xl_all[s] = xl_q;
  end

  logic rd_hit;
  assign rd_hit = int'(rd_off_i[6:0]) < SETS;

  always_comb begin
    rd_data_o = '0;
    if (rd_hit) begin
      if (rd_off_i[7]) rd_data_o = xl_all[rd_off_i[SET_W-1:0]];
      else             rd_data_o = mt_all[rd_off_i[SET_W-1:0]];
    end
  end
endmodule

// File: rtl/spr_file.sv
module spr_file
  import spr_pkg::*;
#(
  parameter int IDX_W     = 16,
  parameter int SPACE_W   = 12,
  parameter int DATA_W    = 32,
  parameter int SCRATCH_N = 16,
  parameter int TLB_SETS  = 16,
  parameter int PAGE_BITS = 13,
  parameter int GPR_N     = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [DATA_W-1:0]        rd_data_o,
  input  logic [DATA_W-1:0]        pc_i,
  input  logic [DATA_W-1:0]        ppc_i,
  input  logic [DATA_W-1:0]        tick_count_i,
  input  logic [DATA_W-1:0]        gpr_rd_data_i,
  output logic [$clog2(GPR_N)-1:0] gpr_rd_idx_o,
  output logic                     gpr_wr_en_o,
  output logic [$clog2(GPR_N)-1:0] gpr_wr_idx_o,
  output logic [DATA_W-1:0]        gpr_wr_data_o,
  output logic                     dc_cmd_valid_o,
  output logic [1:0]               dc_cmd_op_o,
  output logic [DATA_W-1:0]        dc_cmd_addr_o,
  output logic                     ic_cmd_valid_o,
  output logic [1:0]               ic_cmd_op_o,
  output logic [DATA_W-1:0]        ic_cmd_addr_o,
  output logic                     flag_o,
  output logic                     immu_on_o,
  output logic                     immu_off_o,
  output logic                     redirect_o,
  output logic [DATA_W-1:0]        redirect_pc_o,
  output logic [DATA_W-1:0]        fetch_next_o,
  output logic                     tick_wr_o,
  output logic [DATA_W-1:0]        tick_wr_data_o,
  output logic                     suspend_o
);
  localparam int                SCR_W  = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;
  localparam int                GPR_W  = $clog2(GPR_N);
  localparam logic [DATA_W-1:0] SR_RST = DATA_W'(1) << SR_FO_BIT;

  logic rst_n;
  spr_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  // Writes fold into the implemented space; reads are range-checked instead.
  logic [SPACE_W-1:0] wr_loc, rd_loc;
  logic               rd_in_range;
  spr_region_e        wr_region, rd_region;

  assign wr_loc      = wr_idx_i[SPACE_W-1:0];
  assign rd_loc      = rd_idx_i[SPACE_W-1:0];
  assign rd_in_range = (rd_idx_i >> SPACE_W) == '0;

  spr_decode #(.SPACE_W(SPACE_W), .SCRATCH_N(SCRATCH_N), .GPR_N(GPR_N)) u_wr_dec (
    .idx_i(wr_loc), .region_o(wr_region));
  spr_decode #(.SPACE_W(SPACE_W), .SCRATCH_N(SCRATCH_N), .GPR_N(GPR_N)) u_rd_dec (
    .idx_i(rd_loc), .region_o(rd_region));

  // Translation tables, one bank per side.
  logic              dtlb_we, itlb_we;
  logic [DATA_W-1:0] dtlb_rd, itlb_rd;

  assign dtlb_we = wr_en_i && (wr_region == RG_DTLB);
  assign itlb_we = wr_en_i && (wr_region == RG_ITLB);

  spr_tlb_bank #(.DATA_W(DATA_W), .SETS(TLB_SETS), .PAGE_BITS(PAGE_BITS),
                 .MT_FLAGS(32'h0000_00FF), .XL_FLAGS(32'h0000_03FF)) u_dtlb (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(dtlb_we), .wr_off_i(wr_loc[7:0]),
    .wr_data_i(wr_data_i), .rd_off_i(rd_loc[7:0]), .rd_data_o(dtlb_rd));

  spr_tlb_bank #(.DATA_W(DATA_W), .SETS(TLB_SETS), .PAGE_BITS(PAGE_BITS),
                 .MT_FLAGS(32'h0000_00FF), .XL_FLAGS(32'h0000_00FF)) u_itlb (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(itlb_we), .wr_off_i(wr_loc[7:0]),
    .wr_data_i(wr_data_i), .rd_off_i(rd_loc[7:0]), .rd_data_o(itlb_rd));

  // State and strobes.
  logic [DATA_W-1:0] scratch_q [SCRATCH_N];
  logic              scr_we;
  logic [DATA_W-1:0] sr_q, sr_d, pm_q, pm_d, pay_q;
  logic [GPR_W-1:0]  gidx_q;
  cache_op_e         dc_op_q, dc_op_d, ic_op_q, ic_op_d;
  logic dc_v_q, dc_v_d, ic_v_q, ic_v_d, on_q, on_d, off_q, off_d;
  logic redir_q, redir_d, gpr_q, gpr_d, tick_q, tick_d, susp_q, susp_d;
  logic wr_nz, wr_ones;

  assign wr_nz   = |wr_data_i;
  assign wr_ones = &wr_data_i;

  always_comb begin
    dc_v_d  = 1'b0;  dc_op_d = CMD_NONE;
    ic_v_d  = 1'b0;  ic_op_d = CMD_NONE;
    on_d    = 1'b0;  off_d   = 1'b0;
    redir_d = 1'b0;  gpr_d   = 1'b0;
    tick_d  = 1'b0;  susp_d  = 1'b0;
    scr_we  = 1'b0;
    sr_d    = sr_q;  pm_d    = pm_q;
    if (wr_en_i) begin
      case (wr_region)
        RG_SCRATCH: scr_we = 1'b1;
        RG_SR: begin
          sr_d            = wr_data_i;
          sr_d[SR_FO_BIT] = 1'b1;
          on_d  =  wr_data_i[SR_IME_BIT] & ~sr_q[SR_IME_BIT];
          off_d = ~wr_data_i[SR_IME_BIT] &  sr_q[SR_IME_BIT];
        end
        RG_NPC:  redir_d = 1'b1;
        RG_TICK: tick_d  = 1'b1;
        RG_GPR:  gpr_d   = 1'b1;
        RG_PM: begin
          pm_d   = wr_data_i;
          susp_d = wr_data_i[PM_SUSP_BIT];
        end
        RG_DC_PF:  if (wr_nz)    begin dc_v_d = 1'b1; dc_op_d = CMD_PREFETCH; end
        RG_DC_INV: if (wr_nz)    begin dc_v_d = 1'b1; dc_op_d = CMD_INVAL;    end
        RG_DC_FL:  if (!wr_ones) begin dc_v_d = 1'b1; dc_op_d = CMD_FLUSH;    end
        RG_IC_PF:  if (wr_nz)    begin ic_v_d = 1'b1; ic_op_d = CMD_PREFETCH; end
        RG_IC_INV: if (wr_nz)    begin ic_v_d = 1'b1; ic_op_d = CMD_INVAL;    end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= SR_RST;   pm_q    <= '0;
      pay_q   <= '0;       gidx_q  <= '0;
      dc_v_q  <= 1'b0;     dc_op_q <= CMD_NONE;
      ic_v_q  <= 1'b0;     ic_op_q <= CMD_NONE;
      on_q    <= 1'b0;     off_q   <= 1'b0;
      redir_q <= 1'b0;     gpr_q   <= 1'b0;
      tick_q  <= 1'b0;     susp_q  <= 1'b0;
    end else begin
      sr_q    <= sr_d;     pm_q    <= pm_d;
      if (wr_en_i) begin
        pay_q  <= wr_data_i;
        gidx_q <= wr_loc[GPR_W-1:0];
      end
      dc_v_q  <= dc_v_d;   dc_op_q <= dc_op_d;
      ic_v_q  <= ic_v_d;   ic_op_q <= ic_op_d;
      on_q    <= on_d;     off_q   <= off_d;
      redir_q <= redir_d;  gpr_q   <= gpr_d;
      tick_q  <= tick_d;   susp_q  <= susp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SCRATCH_N; i++) scratch_q[i] <= '0;
    end else if (scr_we) begin
      scratch_q[wr_loc[SCR_W-1:0]] <= wr_data_i;
    end
  end

  // Combinational read path.
  always_comb begin
    rd_data_o = '0;
    if (rd_in_range) begin
      case (rd_region)
        RG_SCRATCH: rd_data_o = scratch_q[rd_loc[SCR_W-1:0]];
        RG_NPC:     rd_data_o = pc_i;
        RG_PPC:     rd_data_o = ppc_i;
        RG_SR:      rd_data_o = sr_q;
        RG_TICK:    rd_data_o = tick_count_i;
        RG_PM:      rd_data_o = pm_q;
        RG_DC_FL:   rd_data_o = '1;
        RG_DTLB:    rd_data_o = dtlb_rd;
        RG_ITLB:    rd_data_o = itlb_rd;
        RG_GPR:     rd_data_o = gpr_rd_data_i;
        default:    rd_data_o = '0;
      endcase
    end
  end

  assign gpr_rd_idx_o   = rd_loc[GPR_W-1:0];
  assign gpr_wr_en_o    = gpr_q;
  assign gpr_wr_idx_o   = gidx_q;
  assign gpr_wr_data_o  = pay_q;
  assign dc_cmd_valid_o = dc_v_q;
  assign dc_cmd_op_o    = dc_op_q;
  assign dc_cmd_addr_o  = pay_q;
  assign ic_cmd_valid_o = ic_v_q;
  assign ic_cmd_op_o    = ic_op_q;
  assign ic_cmd_addr_o  = pay_q;
  assign flag_o         = sr_q[SR_F_BIT];
  assign immu_on_o      = on_q;
  assign immu_off_o     = off_q;
  assign redirect_o     = redir_q;
  assign redirect_pc_o  = pay_q;
  assign fetch_next_o   = pay_q + DATA_W'(4);
  assign tick_wr_o      = tick_q;
  assign tick_wr_data_o = pay_q;
  assign suspend_o      = susp_q;
endmodule

// File: rtl/spr_file_chk.sv
module spr_file_chk #(
  parameter int IDX_W   = 16,
  parameter int SPACE_W = 12,
  parameter int DATA_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              gpr_wr_en_o,
  input logic              dc_cmd_valid_o,
  input logic [1:0]        dc_cmd_op_o,
  input logic [DATA_W-1:0] dc_cmd_addr_o,
  input logic              ic_cmd_valid_o,
  input logic [DATA_W-1:0] ic_cmd_addr_o,
  input logic              immu_on_o,
  input logic              immu_off_o,
  input logic              redirect_o,
  input logic [DATA_W-1:0] redirect_pc_o,
  input logic [DATA_W-1:0] fetch_next_o,
  input logic              tick_wr_o,
  input logic              suspend_o
);
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_idx_i >> SPACE_W) != '0) |-> (rd_data_o == '0)); // R1

  AST_DC_CMD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_cmd_valid_o && dc_cmd_op_o != 2'b11) |-> (dc_cmd_addr_o != '0)); // R2

  AST_DC_CMD_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_cmd_valid_o |-> $past(wr_en_i)); // R2

  AST_FLUSH_NOT_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_cmd_valid_o && dc_cmd_op_o == 2'b11) |-> (dc_cmd_addr_o != '1)); // R3

  AST_IC_CMD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ic_cmd_valid_o |-> (ic_cmd_addr_o != '0)); // R5

  AST_SR_FO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == IDX_W'(17)) |-> rd_data_o[15]); // R6

  AST_IMMU_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(immu_on_o && immu_off_o)); // R7

  AST_REDIRECT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (fetch_next_o == redirect_pc_o + DATA_W'(4))); // R8

  AST_GPR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_wr_en_o |-> $past(wr_en_i && wr_idx_i[SPACE_W-1:5] == (SPACE_W-5)'(32))); // R10

  AST_SUSPEND_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> $past(wr_en_i && wr_data_i[4])); // R12

  AST_ONE_SIDE_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dc_cmd_valid_o, ic_cmd_valid_o, redirect_o, gpr_wr_en_o, tick_wr_o, suspend_o})); // R13
endmodule

bind spr_file spr_file_chk #(.IDX_W(IDX_W), .SPACE_W(SPACE_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/spr_file_bench.sv
`timescale 1ns/1ps
module spr_file_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [15:0] wr_idx_i, rd_idx_i;
  logic [31:0] wr_data_i, rd_data_o, pc_i, ppc_i, tick_count_i, gpr_rd_data_i;
  logic [4:0]  gpr_rd_idx_o, gpr_wr_idx_o;
  logic        gpr_wr_en_o, dc_cmd_valid_o, ic_cmd_valid_o, flag_o;
  logic [1:0]  dc_cmd_op_o, ic_cmd_op_o;
  logic [31:0] gpr_wr_data_o, dc_cmd_addr_o, ic_cmd_addr_o, redirect_pc_o, fetch_next_o, tick_wr_data_o;
  logic        immu_on_o, immu_off_o, redirect_o, tick_wr_o, suspend_o;

  always #4 clk_i = ~clk_i;

  spr_file u_spr_file (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // Reference model state
  bit [31:0] m_scr [16];
  bit [31:0] m_dt [256];
  bit [31:0] m_it [256];
  bit [31:0] m_sr, m_pm;
  bit        e_dc_v, e_ic_v, e_on, e_off, e_redir, e_gpr, e_tick, e_susp;
  bit [1:0]  e_dc_op, e_ic_op;
  bit [31:0] e_pay;
  bit [4:0]  e_gidx;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] mread(int r);
    int off;
    if (r >= 4096) return 32'h0;
    if (r < 16) return m_scr[r];
    if (r >= 'h100 && r < 'h200) begin off = r - 'h100; return m_dt[off]; end
    if (r >= 'h200 && r < 'h300) begin off = r - 'h200; return m_it[off]; end
    if (r >= 'h400 && r < 'h420) return gpr_rd_data_i;
    case (r)
      'h010: return pc_i;
      'h012: return ppc_i;
      'h011: return m_sr;
      'h020: return tick_count_i;
      'h030: return m_pm;
      'h041: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic mwrite(bit [15:0] wi, bit [31:0] d);
    int r, off;
    r = int'(wi) % 4096;
    e_pay = d; e_gidx = wi[4:0];
    if (r < 16) m_scr[r] = d;
    else if (r >= 'h100 && r < 'h300) begin
      off = r & 'hFF;
      if (off < 16)
        begin if (r < 'h200) m_dt[off] = d & 32'hFFFF_E0FF; else m_it[off] = d & 32'hFFFF_E0FF; end
      else if (off >= 'h80 && off < 'h90)
        begin if (r < 'h200) m_dt[off] = d & 32'hFFFF_E3FF; else m_it[off] = d & 32'hFFFF_E0FF; end
    end
    else if (r >= 'h400 && r < 'h420) e_gpr = 1;
    else case (r)
      'h010: e_redir = 1;
      'h011: begin
        e_on  = d[6] && !m_sr[6];
        e_off = !d[6] && m_sr[6];
        m_sr  = d | 32'h8000;
      end
      'h020: e_tick = 1;
      'h030: begin m_pm = d; e_susp = d[4]; end
      'h040: if (d != 0) begin e_dc_v = 1; e_dc_op = 2'b01; end
      'h042: if (d != 0) begin e_dc_v = 1; e_dc_op = 2'b10; end
      'h041: if (d != 32'hFFFF_FFFF) begin e_dc_v = 1; e_dc_op = 2'b11; end
      'h048: if (d != 0) begin e_ic_v = 1; e_ic_op = 2'b01; end
      'h049: if (d != 0) begin e_ic_v = 1; e_ic_op = 2'b10; end
      default: ;
    endcase
  endtask

  task automatic compare_outputs();
    check("R2 dc valid", 32'(dc_cmd_valid_o), 32'(e_dc_v));
    if (e_dc_v) begin
      check(e_dc_op == 2'b11 ? "R3 dc op" : "R2 dc op", 32'(dc_cmd_op_o), 32'(e_dc_op));
      check("R2 dc addr", dc_cmd_addr_o, e_pay);
    end
    check("R5 ic valid", 32'(ic_cmd_valid_o), 32'(e_ic_v));
    if (e_ic_v) begin
      check("R5 ic op", 32'(ic_cmd_op_o), 32'(e_ic_op));
      check("R5 ic addr", ic_cmd_addr_o, e_pay);
    end
    check("R6 flag", 32'(flag_o), 32'(m_sr[0]));
    check("R7 immu on", 32'(immu_on_o), 32'(e_on));
    check("R7 immu off", 32'(immu_off_o), 32'(e_off));
    check("R8 redirect", 32'(redirect_o), 32'(e_redir));
    if (e_redir) begin
      check("R8 redirect pc", redirect_pc_o, e_pay);
      check("R8 fetch next", fetch_next_o, e_pay + 32'd4);
    end
    check("R10 gpr wr", 32'(gpr_wr_en_o), 32'(e_gpr));
    if (e_gpr) begin
      check("R10 gpr idx", 32'(gpr_wr_idx_o), 32'(e_gidx));
      check("R10 gpr data", gpr_wr_data_o, e_pay);
    end
    check("R11 tick wr", 32'(tick_wr_o), 32'(e_tick));
    if (e_tick) check("R11 tick data", tick_wr_data_o, e_pay);
    check("R12 suspend", 32'(suspend_o), 32'(e_susp));
  endtask

  // One cycle: drive at the falling edge, check the read before the rising
  // edge, update the model at the rising edge, check strobes at the next fall.
  task automatic step(bit we, bit [15:0] wi, bit [31:0] wd, bit [15:0] ri, string rtag);
    wr_en_i = we; wr_idx_i = wi; wr_data_i = wd; rd_idx_i = ri;
    pc_i = $urandom; ppc_i = $urandom; tick_count_i = $urandom; gpr_rd_data_i = $urandom;
    #1;
    check(rtag, rd_data_o, mread(int'(ri)));
    check("R10 gpr rd idx", 32'(gpr_rd_idx_o), 32'(ri[4:0]));
    @(posedge clk_i);
    {e_dc_v, e_ic_v, e_on, e_off, e_redir, e_gpr, e_tick, e_susp} = '0;
    if (we) mwrite(wi, wd);
    @(negedge clk_i);
    compare_outputs();
  endtask

  task automatic wr(bit [15:0] wi, bit [31:0] wd, bit [15:0] ri, string rtag);
    step(1'b1, wi, wd, ri, rtag);
  endtask

  task automatic rd(bit [15:0] ri, string rtag);
    step(1'b0, 16'h0, 32'h0, ri, rtag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  int unsigned pick [24] = '{'h003, 'h00F, 'h010, 'h011, 'h012, 'h020, 'h030, 'h040,
                             'h041, 'h042, 'h043, 'h044, 'h048, 'h049, 'h04A, 'h103,
                             'h183, 'h203, 'h28F, 'h40C, 'h1011, 'hF041, 'h777, 'h41F};

  initial begin
    for (int i = 0; i < 16; i++) m_scr[i] = 0;
    for (int i = 0; i < 256; i++) begin m_dt[i] = 0; m_it[i] = 0; end
    m_sr = 32'h8000; m_pm = 0; e_pay = 0; e_gidx = 0;
    {e_dc_v, e_ic_v, e_on, e_off, e_redir, e_gpr, e_tick, e_susp} = '0;
    e_dc_op = 0; e_ic_op = 0;
    rst_ni = 1'b0; wr_en_i = 0; wr_idx_i = 0; wr_data_i = 0; rd_idx_i = 0;
    pc_i = 0; ppc_i = 0; tick_count_i = 0; gpr_rd_data_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R13 reset state
    check("R13 reset dc", 32'(dc_cmd_valid_o), 0);
    check("R13 reset ic", 32'(ic_cmd_valid_o), 0);
    check("R13 reset redirect", 32'(redirect_o), 0);
    check("R13 reset suspend", 32'(suspend_o), 0);
    rd(16'h0011, "R6 reset SR");

    // R13 scratch storage and unmapped reads
    wr(16'h0005, 32'hA5A5_0001, 16'h0005, "R13 scratch before");
    rd(16'h0005, "R13 scratch readback");
    rd(16'h00FF, "R13 unmapped");
    // R1 write folding and out-of-range reads
    wr(16'h3007, 32'h1234_5678, 16'h0007, "R1 pre");
    rd(16'h0007, "R1 folded write");
    rd(16'h1007, "R1 out of range");
    // R2 data cache prefetch / invalidate
    wr(16'h0040, 32'h0000_1000, 16'h0040, "R2 read zero");
    rd(16'h0040, "R2 prefetch reads zero");
    wr(16'h0040, 32'h0, 16'h0042, "R2 zero write");
    wr(16'h0042, 32'h0000_2000, 16'h0042, "R2 inval reads zero");
    // R3 flush
    wr(16'h0041, 32'h0000_3000, 16'h0041, "R3 flush reads ones");
    wr(16'h0041, 32'hFFFF_FFFF, 16'h0041, "R3 ones write");
    // R4 write-back and lock registers
    wr(16'h0043, 32'h5, 16'h0043, "R4 wb");
    wr(16'h0044, 32'h6, 16'h0043, "R4 wb after");
    wr(16'h004A, 32'h7, 16'h0044, "R4 dlock");
    rd(16'h004A, "R4 ilock");
    // R5 instruction cache
    wr(16'h0048, 32'h0000_4000, 16'h0048, "R5 prefetch");
    wr(16'h0049, 32'h0000_5000, 16'h0049, "R5 inval");
    wr(16'h0049, 32'h0, 16'h0049, "R5 zero");
    // R6 / R7 status register
    wr(16'h0011, 32'h0000_0001, 16'h0011, "R6 pre");
    rd(16'h0011, "R6 fixed one and flag");
    wr(16'h0011, 32'h0000_0040, 16'h0011, "R7 enable");
    wr(16'h0011, 32'h0000_0041, 16'h0011, "R7 unchanged");
    wr(16'h0011, 32'h0000_0000, 16'h0011, "R7 disable");
    rd(16'h0011, "R6 after clear");
    // R8 next PC
    wr(16'h0010, 32'h0000_0100, 16'h0010, "R8 npc read");
    rd(16'h0012, "R8 ppc read");
    wr(16'h0010, 32'hFFFF_FFFC, 16'h0010, "R8 wrap");
    // R9 translation tables
    wr(16'h0105, 32'hFFFF_FFFF, 16'h0105, "R9 pre");
    wr(16'h0185, 32'hFFFF_FFFF, 16'h0105, "R9 dtlb match mask");
    wr(16'h0285, 32'hFFFF_FFFF, 16'h0185, "R9 dtlb xlat mask");
    wr(16'h0205, 32'hFFFF_FFFF, 16'h0285, "R9 itlb xlat mask");
    wr(16'h0120, 32'hFFFF_FFFF, 16'h0205, "R9 itlb match mask");
    rd(16'h0120, "R9 unimplemented set");
    // R10 GPR window
    wr(16'h041F, 32'h0000_DEAD, 16'h040A, "R10 read alias");
    wr(16'h0400, 32'h0000_BEEF, 16'h0420, "R10 past window");
    // R11 timer
    wr(16'h0020, 32'd77, 16'h0020, "R11 live count");
    // R12 power management
    wr(16'h0030, 32'h0000_0010, 16'h0030, "R12 pre");
    wr(16'h0030, 32'h0000_000F, 16'h0030, "R12 stored");
    rd(16'h0030, "R12 other bits stored");

    // Mixed random sequence
    for (int n = 0; n < 600; n++) begin
      bit [31:0] d;
      case ($urandom_range(0, 3))
        0: d = 32'h0;
        1: d = 32'hFFFF_FFFF;
        default: d = $urandom;
      endcase
      step(1'($urandom_range(0, 1)), 16'(pick[$urandom_range(0, 23)]), d,
           16'(pick[$urandom_range(0, 23)]), "R13 random read");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule